// File: doc/BRIEF.md
# Pipelined ADC Code Combiner with Stage Calibration

This block is the digital back end of a 13-stage pipelined converter whose stages each resolve 1.5 bits. At every conversion strobe it takes one two-bit decision from each stage. Each stage's decision belongs to a different sample, because stage k works on the sample that entered the pipeline k strobes earlier. Per-stage skew registers line up the thirteen decisions of one sample. The block then forms the redundant sum in which every stage weighs half as much as the stage before it. This overlapped sum absorbs comparator offsets.

For the eight most significant stages, a signed calibration term is held for each possible decision. The sum of the selected terms is subtracted from the overlapped sum. This removes the errors that capacitor mismatch and finite amplifier gain leave in those stages. The difference is halved to a 13-bit word and clamped to the output range. The coefficients are loaded through a small write port. They are measured outside this block.

Top module: `adc_dcorr`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `valid_o`=0, `result_o`=0, `err_o`=0, and every calibration coefficient is cleared to zero.
- R2: The pipeline advances only on a cycle with `valid_i`=1. At such a strobe, stage k (bits 2k+1:2k of `codes_i`) carries the code of the sample first presented k strobes earlier. The result of that sample appears with `valid_o`=1 in the cycle after the strobe that carries its stage-12 code.
- R3: The first 12 strobes after reset produce no output (`valid_o` stays 0). From the 13th strobe on, every strobe produces one.
- R4: Code levels are 00=0, 01=1 and 10=2. The overlapped sum is S = sum over k of level_k * 2^(12-k), and without calibration `result_o` = floor(S/2).
- R5: For stages 0..7, the coefficient stored for (stage, level) is subtracted from S before halving, in units of half an output LSB: `result_o` = floor((S - sum cal[k][level_k]) / 2).
- R6: When the calibrated value is below 0 the output is 0, and when it exceeds 8191 the output is 8191; it never wraps.
- R7: Code 11 is illegal. It counts as level 2 in the sum and selects the level-2 coefficient. `err_o` is high together with `valid_o` for any sample that has at least one such code, and low otherwise.
- R8: A write (`cal_we_i`=1) stores `cal_data_i` at (`cal_stage_i`, `cal_code_i`) and takes effect on strobes after that cycle. A write with stage >= 8 or code 11 changes no coefficient.
- R9: In a cycle without a strobe, `valid_o` is 0 in the next cycle, `result_o` holds its value, and no stored code moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Conversion strobe: all stage codes valid this cycle |
| codes_i | input | 26 | Stage decisions; stage k in bits 2k+1:2k |
| cal_we_i | input | 1 | Coefficient write enable |
| cal_stage_i | input | 4 | Stage index of the coefficient written |
| cal_code_i | input | 2 | Code level of the coefficient written |
| cal_data_i | input | 10 | Signed coefficient, in half output LSBs |
| result_o | output | 13 | Corrected and clamped output word |
| valid_o | output | 1 | Result valid, one cycle per completed sample |
| err_o | output | 1 | Sample held an illegal 11 code |

## Verification
The bench builds the block with its defaults: 13 stages, 8 calibrated stages and 10-bit signed coefficients. With these values the summed coefficients can move the overlapped sum by up to about ±4096 half-LSBs. All-10 samples with negative level-2 terms therefore cross the upper rail, and all-00 samples with positive level-0 terms cross the lower one. Because the skew depths are unequal, a wrong delay on any single stage corrupts the random-code samples.

// File: rtl/adc_dcorr_pkg.sv
package adc_dcorr_pkg;

    typedef logic [1:0] code_t;

    localparam code_t CODE_BAD = 2'b11;

    // level used in the sum and for coefficient lookup; illegal code counts as 2
    function automatic logic [1:0] code_level(code_t c);
        return (c == CODE_BAD) ? 2'd2 : c;
    endfunction

endpackage

// File: rtl/adc_dcorr_skew.sv
module adc_dcorr_skew #(
    parameter int NSTAGE = 13
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic [NSTAGE*2-1:0]   codes_i,
    output logic [NSTAGE*2-1:0]   aligned_o
);

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        localparam int D = NSTAGE - 1 - k;
        if (D == 0) begin : g_direct
            assign aligned_o[2*k +: 2] = codes_i[2*k +: 2];
        end else if (D == 1) begin : g_one
            logic [1:0] hold_q;
            always_ff @(posedge clk) begin
                if (rst)      hold_q <= '0;
                else if (adv) hold_q <= codes_i[2*k +: 2];
            end
            assign aligned_o[2*k +: 2] = hold_q;
        end else begin : g_chain
            logic [2*D-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst)      chain_q <= '0;
                else if (adv) chain_q <= {chain_q[2*D-3:0], codes_i[2*k +: 2]};
            end
            assign aligned_o[2*k +: 2] = chain_q[2*D-1 -: 2];
        end
    end

    // R9
    skew_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(aligned_o[NSTAGE*2-3:0]));

endmodule

// File: rtl/adc_dcorr_cal.sv
module adc_dcorr_cal
    import adc_dcorr_pkg::*;
#(
    parameter int NSTAGE = 13,
    parameter int NCAL   = 8,
    parameter int CAL_W  = 10,
    parameter int SAW    = 4,
    parameter int SUM_W  = 25
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  logic [SAW-1:0]           stage_i,
    input  logic [1:0]               code_i,
    input  logic [CAL_W-1:0]         data_i,
    input  logic [NSTAGE*2-1:0]      aligned_i,
    output logic signed [SUM_W-1:0]  cal_sum_o
);

    localparam int NENT = NCAL * 3;

    logic [NENT*CAL_W-1:0] tab_q;
    logic                  wr_ok;
    int                    wr_idx;

    assign wr_ok  = we_i && (int'(stage_i) < NCAL) && (code_i != CODE_BAD);
    assign wr_idx = int'(stage_i) * 3 + int'(code_i);

    always_ff @(posedge clk) begin
        if (rst)        tab_q <= '0;
        else if (wr_ok) tab_q[wr_idx*CAL_W +: CAL_W] <= data_i;
    end

    always_comb begin
        logic signed [CAL_W-1:0] term;
        logic [1:0]              lvl;
        cal_sum_o = '0;
        for (int k = 0; k < NCAL; k++) begin
            lvl       = code_level(aligned_i[2*k +: 2]);
            term      = tab_q[(k*3 + int'(lvl))*CAL_W +: CAL_W];
            cal_sum_o = cal_sum_o + SUM_W'(term);
        end
    end

    // R8
    cal_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && ((int'(stage_i) >= NCAL) || (code_i == CODE_BAD))) |=> $stable(tab_q));

endmodule

// File: rtl/adc_dcorr_sum.sv
module adc_dcorr_sum
    import adc_dcorr_pkg::*;
#(
    parameter int NSTAGE = 13,
    parameter int SUM_W  = 25
) (
    input  logic [NSTAGE*2-1:0]      aligned_i,
    input  logic signed [SUM_W-1:0]  cal_sum_i,
    output logic [NSTAGE-1:0]        result_o,
    output logic                     bad_o
);

    localparam logic signed [SUM_W-1:0] TOP = SUM_W'((1 << NSTAGE) - 1);

    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] diff;
    logic signed [SUM_W-1:0] half;

    always_comb begin
        acc   = '0;
        bad_o = 1'b0;
        for (int k = 0; k < NSTAGE; k++) begin
            acc = acc + (signed'(SUM_W'(code_level(aligned_i[2*k +: 2]))) <<< (NSTAGE - 1 - k));
            if (aligned_i[2*k +: 2] == CODE_BAD) bad_o = 1'b1;
        end
        diff = acc - cal_sum_i;
        half = diff >>> 1;
        if (half < 0)        result_o = '0;
        else if (half > TOP) result_o = TOP[NSTAGE-1:0];
        else                 result_o = half[NSTAGE-1:0];
    end

endmodule

// File: rtl/adc_dcorr.sv
module adc_dcorr
    import adc_dcorr_pkg::*;
#(
    parameter int NSTAGE = 13,
    parameter int NCAL   = 8,
    parameter int CAL_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_i,
    input  logic [NSTAGE*2-1:0]  codes_i,
    input  logic                 cal_we_i,
    input  logic [$clog2(NSTAGE)-1:0] cal_stage_i,
    input  logic [1:0]           cal_code_i,
    input  logic [CAL_W-1:0]     cal_data_i,
    output logic [NSTAGE-1:0]    result_o,
    output logic                 valid_o,
    output logic                 err_o
);

    localparam int SAW   = $clog2(NSTAGE);
    localparam int CNT_W = $clog2(NSTAGE);
    localparam int SUM_W = NSTAGE + CAL_W + 2;

    logic [NSTAGE*2-1:0]      aligned;
    logic signed [SUM_W-1:0]  cal_sum;
    logic [NSTAGE-1:0]        res_c;
    logic                     bad_c;
    logic [CNT_W-1:0]         fill_q;
    logic                     full;

    adc_dcorr_skew #(.NSTAGE(NSTAGE)) u_skew (
        .clk(clk), .rst(rst), .adv(valid_i),
        .codes_i(codes_i), .aligned_o(aligned)
    );

    adc_dcorr_cal #(
        .NSTAGE(NSTAGE), .NCAL(NCAL), .CAL_W(CAL_W), .SAW(SAW), .SUM_W(SUM_W)
    ) u_cal (
        .clk(clk), .rst(rst), .we_i(cal_we_i), .stage_i(cal_stage_i),
        .code_i(cal_code_i), .data_i(cal_data_i),
        .aligned_i(aligned), .cal_sum_o(cal_sum)
    );

    adc_dcorr_sum #(.NSTAGE(NSTAGE), .SUM_W(SUM_W)) u_sum (
        .aligned_i(aligned), .cal_sum_i(cal_sum),
        .result_o(res_c), .bad_o(bad_c)
    );

    assign full = (fill_q == CNT_W'(NSTAGE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q   <= '0;
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
            result_o <= '0;
        end else begin
            valid_o <= valid_i && full;
            err_o   <= valid_i && full && bad_c;
            if (valid_i && !full) fill_q <= fill_q + 1'b1;
            if (valid_i && full)  result_o <= res_c;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && !err_o && result_o == '0));

    // R2
    out_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(valid_i));

    // R7
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> valid_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!valid_o && $stable(result_o)));

endmodule

// File: tb/adc_dcorr_tb.sv
module adc_dcorr_tb;

    localparam int NST  = 13;
    localparam int NC   = 8;
    localparam int CW   = 10;
    localparam int MAXS = 512;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            valid_i = 1'b0;
    logic [NST*2-1:0] codes_i = '0;
    logic            cal_we_i = 1'b0;
    logic [3:0]      cal_stage_i = '0;
    logic [1:0]      cal_code_i = '0;
    logic [CW-1:0]   cal_data_i = '0;
    logic [NST-1:0]  result_o;
    logic            valid_o;
    logic            err_o;

    int checks = 0;
    int fails  = 0;
    int g      = 0;
    logic [1:0] smp [MAXS][NST];
    int calm [NC][3];

    always #2 clk = ~clk;

    adc_dcorr u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .codes_i(codes_i),
        .cal_we_i(cal_we_i), .cal_stage_i(cal_stage_i), .cal_code_i(cal_code_i),
        .cal_data_i(cal_data_i), .result_o(result_o), .valid_o(valid_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lvl(input logic [1:0] c);
        return (c == 2'b11) ? 2 : int'(c);
    endfunction

    function automatic int model_res(input int s);
        int acc = 0;
        for (int k = 0; k < NST; k++) acc += lvl(smp[s][k]) << (NST - 1 - k);
        for (int k = 0; k < NC; k++)  acc -= calm[k][lvl(smp[s][k])];
        if (acc < 0) return 0;
        if (acc / 2 > 8191) return 8191;
        return acc / 2;
    endfunction

    function automatic bit model_err(input int s);
        for (int k = 0; k < NST; k++) if (smp[s][k] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    // one strobe; inputs change 1 ns after the edge, outputs read 1 ns after the edge
    task automatic strobe(input string req);
        for (int k = 0; k < NST; k++)
            codes_i[2*k +: 2] = (g - k >= 0) ? smp[(g - k) % MAXS][k] : 2'b00;
        valid_i = 1'b1;
        @(posedge clk); #1;
        valid_i = 1'b0;
        if (g >= NST - 1) begin
            chk(valid_o == 1'b1, {req, " valid"}, int'(valid_o), 1);
            chk(int'(result_o) == model_res((g - NST + 1) % MAXS), req,
                int'(result_o), model_res((g - NST + 1) % MAXS));
            chk(err_o == model_err((g - NST + 1) % MAXS), {req, " err"},
                int'(err_o), int'(model_err((g - NST + 1) % MAXS)));
        end else begin
            chk(valid_o == 1'b0, "R3 no output during fill", int'(valid_o), 0);
        end
        g++;
    endtask

    task automatic cal_write(input int st, input int cd, input int val);
        cal_we_i = 1'b1; cal_stage_i = 4'(st); cal_code_i = 2'(cd); cal_data_i = CW'(val);
        @(posedge clk); #1;
        cal_we_i = 1'b0;
        if (st < NC && cd != 3) calm[st][cd] = val;
    endtask

    // mode 0 random legal, 1 all 01, 2 all 10, 3 all 00, 4 random with illegal
    task automatic fill(input int n, input int mode);
        for (int i = 0; i < n; i++)
            for (int k = 0; k < NST; k++)
                case (mode)
                    0: smp[(g + i) % MAXS][k] = 2'($urandom_range(0, 2));
                    1: smp[(g + i) % MAXS][k] = 2'b01;
                    2: smp[(g + i) % MAXS][k] = 2'b10;
                    3: smp[(g + i) % MAXS][k] = 2'b00;
                    default: smp[(g + i) % MAXS][k] = 2'($urandom_range(0, 3));
                endcase
    endtask

    task automatic t_reset();
        chk(valid_o == 1'b0, "R1 valid after reset", int'(valid_o), 0);
        chk(result_o == '0, "R1 result after reset", int'(result_o), 0);
        chk(err_o == 1'b0, "R1 err after reset", int'(err_o), 0);
    endtask

    task automatic t_uncal();
        fill(40, 0);
        for (int i = 0; i < 40; i++) strobe("R2 R4 uncalibrated sum");
        // single-stage weights: stage k alone at level 1
        for (int k = 0; k < NST; k++) begin
            for (int j = 0; j < NST; j++) smp[(g + k) % MAXS][j] = (j == k) ? 2'b01 : 2'b00;
        end
        for (int i = 0; i < NST; i++) strobe("R4 stage weight");
        fill(NST, 3);
        for (int i = 0; i < NST; i++) strobe("R4 stage weight flush");
    endtask

    task automatic t_gaps();
        logic [NST-1:0] held;
        fill(20, 0);
        for (int i = 0; i < 20; i++) begin
            strobe("R9 strobe with gaps");
            held = result_o;
            for (int j = 0; j < (i % 3) + 1; j++) begin
                @(posedge clk); #1;
                chk(valid_o == 1'b0, "R9 idle valid", int'(valid_o), 0);
                chk(result_o == held, "R9 idle hold", int'(result_o), int'(held));
            end
        end
    endtask

    task automatic t_cal();
        for (int k = 0; k < NC; k++)
            for (int c = 0; c < 3; c++) cal_write(k, c, $urandom_range(0, 200) - 100);
        fill(30, 0);
        for (int i = 0; i < 30; i++) strobe("R5 R8 calibrated sum");
    endtask

    task automatic t_sat();
        for (int k = 0; k < NC; k++) begin
            cal_write(k, 2, -100);
            cal_write(k, 0, 100);
        end
        fill(15, 2);
        for (int i = 0; i < 15; i++) strobe("R6 upper clamp");
        chk(int'(result_o) == 8191, "R6 upper rail", int'(result_o), 8191);
        fill(15, 3);
        for (int i = 0; i < 15; i++) strobe("R6 lower clamp");
        chk(int'(result_o) == 0, "R6 lower rail", int'(result_o), 0);
    endtask

    task automatic t_illegal();
        fill(30, 4);
        for (int k = 0; k < NST; k++) smp[g % MAXS][k] = 2'b11;
        for (int i = 0; i < 30; i++) strobe("R7 illegal code");
        fill(NST, 1);
        for (int i = 0; i < NST; i++) strobe("R7 illegal flush");
    endtask

    task automatic t_ignored();
        cal_write(1, 0, 40);
        cal_write(2, 2, 0);
        cal_write(9, 0, 300);
        cal_write(2, 3, 200);
        cal_write(12, 1, -250);
        for (int i = 0; i < NST + 2; i++)
            for (int k = 0; k < NST; k++)
                smp[(g + i) % MAXS][k] = (k == 1) ? 2'b00 : (k == 2) ? 2'b11 : 2'b01;
        for (int i = 0; i < NST + 2; i++) strobe("R8 ignored write");
    endtask

    initial begin
        for (int k = 0; k < NC; k++) for (int c = 0; c < 3; c++) calm[k][c] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_uncal();
        t_gaps();
        t_cal();
        t_sat();
        t_illegal();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule